// File: doc/BRIEF.md
# Configuration Port Unlock Gate

This block puts a small configuration space behind a pair of bus addresses. The lower address takes index writes, and the address just above it carries the data. Nothing inside the space is reachable until the host writes an entry key byte twice in a row to the lower address. A separate exit key written to the same address closes the space again. While the space is open, the host writes a register number to the lower address. It then reads or writes that register through the upper address.

Two register numbers are handled inside the block. One holds the number of the logical device currently selected. The other returns a fixed chip identifier and cannot be written. Every other register number is passed through to the logical devices on a simple register bus. That bus carries read and write strobes, the register number, the write data and the selected device number, and it accepts read data back. An input strap picks which of two base addresses the pair sits at.

Top module: `cfg_unlock_port`

## Requirements
- R1: Reset leaves the port locked, with the latched register number at 0x00 and the device number at 0x00. After a later unlock, a read of the index address returns 0x00.
- R2: The port unlocks on the second of two consecutive writes of 0x87 to the index address. A single 0x87 write leaves it locked. `unlocked` goes high in the cycle after the second key write.
- R3: While the port is locked, any write to either port address breaks a partial key sequence. That includes an index write of any value other than 0x87, or a write to the data address. After such a write, two fresh 0x87 writes are needed.
- R4: While the port is locked, reads of the data address return 0xFF, writes to it change nothing, and `reg_wr` and `reg_rd` stay low.
- R5: Writing 0xAA to the index address while unlocked locks the port from the next cycle. The latched register number and the device number are kept.
- R6: While unlocked, a data-address read of any register number other than 0x07 and 0x20 raises `reg_rd` in the same cycle. It presents that number on `reg_idx` and returns `reg_rdata` on `bus_rdata` combinationally.
- R7: While unlocked, a data-address write to any register number other than 0x07 and 0x20 raises `reg_wr` in the same cycle. `reg_idx`, `reg_wdata` and `reg_dev` carry the register number, the data and the device number.
- R8: Register number 0x07 holds the device number. A data write to it updates `reg_dev` from the next cycle without raising `reg_wr`, and a data read of it returns the stored value without raising `reg_rd`.
- R9: Register number 0x20 reads back the CHIP_ID parameter (default 0xA3). A data write to it raises no strobe and has no effect.
- R10: With `base_alt` low the port sits at 0x2E (index) and 0x2F (data). With `base_alt` high it sits at 0x4E and 0x4F. Accesses to any other address have no effect and read 0xFF.
- R11: A read of the index address returns the latched register number while the port is unlocked, and 0xFF while it is locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_alt | input | 1 | Base select: 0 for 0x2E/0x2F, 1 for 0x4E/0x4F |
| bus_addr | input | ADDR_W | Host bus address |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| reg_wr | output | 1 | Write strobe toward the logical devices |
| reg_rd | output | 1 | Read strobe toward the logical devices |
| reg_idx | output | 8 | Register number toward the logical devices |
| reg_wdata | output | 8 | Write data toward the logical devices |
| reg_rdata | input | 8 | Read data from the selected logical device |
| reg_dev | output | 8 | Currently selected logical device number |
| unlocked | output | 1 | High while extended configuration mode is open |

## Verification
The bench attacks the key tracker with broken sequences: a lone key, a foreign byte between the keys, and a data write between the keys. A tracker that only counted key bytes would open early on any of these. It checks that the two internal register numbers never leak onto the device bus and that the identifier cannot be overwritten; a faulty decode would show a stray `reg_wr` or a changed readback. It also moves the base strap and probes the old addresses, and it reads through the port after an exit, which exposes a mux that still forwards data while locked.

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port #(
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  CHIP_ID   = 8'hA3,
  parameter logic [7:0]  KEY_ENTER = 8'h87,
  parameter logic [7:0]  KEY_EXIT  = 8'hAA,
  parameter logic [7:0]  DEV_INDEX = 8'h07,
  parameter logic [7:0]  ID_INDEX  = 8'h20,
  parameter int          BASE_LO   = 'h2E,
  parameter int          BASE_HI   = 'h4E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_alt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [7:0]        reg_idx,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic [7:0]        reg_dev,
  output logic              unlocked
);

  localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(BASE_HI);
  localparam logic [7:0]        IDLE_RD = 8'hFF;

  logic              unl_q, half_q;
  logic [7:0]        index_q, dev_q;
  logic [ADDR_W-1:0] base;
  logic              idx_hit, dat_hit, idx_wr, dat_wr, dat_rd, local_reg;

  assign base      = base_alt ? HI_IDX : LO_IDX;
  assign idx_hit   = bus_addr == base;
  assign dat_hit   = bus_addr == base + ADDR_W'(1);
  assign idx_wr    = bus_wr & idx_hit;
  assign dat_wr    = bus_wr & dat_hit;
  assign dat_rd    = bus_rd & dat_hit;
  assign local_reg = (index_q == DEV_INDEX) || (index_q == ID_INDEX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unl_q   <= 1'b0;
      half_q  <= 1'b0;
      index_q <= 8'h00;
      dev_q   <= 8'h00;
    end else if (!unl_q) begin
      if (idx_wr && bus_wdata == KEY_ENTER) begin
        unl_q  <= half_q;
        half_q <= ~half_q;
      end else if (idx_wr || dat_wr) begin
        half_q <= 1'b0;
      end
    end else begin
      if (idx_wr) begin
        if (bus_wdata == KEY_EXIT) unl_q <= 1'b0;
        else                       index_q <= bus_wdata;
      end
      if (dat_wr && index_q == DEV_INDEX) dev_q <= bus_wdata;
    end
  end

  assign unlocked  = unl_q;
  assign reg_wr    = unl_q & dat_wr & ~local_reg;
  assign reg_rd    = unl_q & dat_rd & ~local_reg;
  assign reg_idx   = index_q;
  assign reg_wdata = bus_wdata;
  assign reg_dev   = dev_q;

  always_comb begin
    bus_rdata = IDLE_RD;
    if (unl_q && idx_hit)
      bus_rdata = index_q;
    else if (unl_q && dat_hit) begin
      if (index_q == DEV_INDEX)     bus_rdata = dev_q;
      else if (index_q == ID_INDEX) bus_rdata = CHIP_ID;
      else                          bus_rdata = reg_rdata;
    end
  end

  // locked port never drives the device bus
  p_quiet_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!reg_wr && !reg_rd));

  p_unlock_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(bus_wr) && $past(bus_wdata) == KEY_ENTER));

  p_exit_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && bus_wdata == KEY_EXIT) |=> !unlocked);

  p_local_not_forwarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_idx != DEV_INDEX && reg_idx != ID_INDEX));

  p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlocked && dat_wr && reg_idx == DEV_INDEX) |=> $stable(reg_dev));

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_rd) |-> bus_rdata == 8'hFF);

endmodule

// File: tb/cfg_unlock_port_tb_top.sv
module cfg_unlock_port_tb_top;
  logic clk = 0, rst_n = 0, base_alt = 0;
  logic [15:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, reg_idx, reg_wdata, reg_rdata, reg_dev;
  logic reg_wr, reg_rd, unlocked;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign reg_rdata = reg_idx ^ reg_dev ^ 8'h5A;

  cfg_unlock_port dut_i (.clk(clk), .rst_n(rst_n), .base_alt(base_alt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_dev(reg_dev),
    .unlocked(unlocked));

  typedef struct {
    int         kind;
    logic [7:0] d;
    logic       s;
    logic [7:0] i;
    logic [7:0] v;
    string      tag;
  } item_t;
  item_t q[$];

  task automatic push(input int k, input logic [7:0] d, input logic s,
                      input logic [7:0] i, input logic [7:0] v, input string tag);
    item_t it;
    it.kind = k; it.d = d; it.s = s; it.i = i; it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ew,
                    input logic [7:0] ei, input logic [7:0] ev, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    push(1, d, ew, ei, ev, tag);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] ed, input logic es,
                    input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 0; bus_rd = 1;
    push(0, ed, es, 0, 0, tag);
  endtask

  task automatic chk_state(input logic eu, input logic [7:0] ev, input string tag);
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
    push(2, 0, eu, 0, ev, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic fail(input string tag, input string what, input int act, input int exp);
    bad++;
    $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // monitor: pops one expected item per cycle in which one is pending
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      case (it.kind)
        0: begin
          if (bus_rdata !== it.d) fail(it.tag, "rdata", bus_rdata, it.d);
          else if (reg_rd !== it.s) fail(it.tag, "reg_rd", reg_rd, it.s);
        end
        1: begin
          if (reg_wr !== it.s) fail(it.tag, "reg_wr", reg_wr, it.s);
          else if (it.s && (reg_idx !== it.i || reg_wdata !== it.d || reg_dev !== it.v))
            fail(it.tag, "reg bus", {reg_idx, reg_wdata, reg_dev}, {it.i, it.d, it.v});
        end
        default: begin
          if (unlocked !== it.s) fail(it.tag, "unlocked", unlocked, it.s);
          else if (reg_dev !== it.v) fail(it.tag, "reg_dev", reg_dev, it.v);
        end
      endcase
    end
  end

  localparam logic [15:0] I0 = 16'h2E, D0 = 16'h2F, I1 = 16'h4E, D1 = 16'h4F;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_state(0, 8'h00, "R1 reset state");
    rd(D0, 8'hFF, 0, "R4 locked data read");
    rd(I0, 8'hFF, 0, "R11 locked index read");
    wr(I0, 8'h87, 0, 0, 0, "R2 first key");
    chk_state(0, 8'h00, "R2 single key stays locked");
    wr(I0, 8'h55, 0, 0, 0, "R3 foreign byte");
    wr(I0, 8'h87, 0, 0, 0, "R3 key after foreign");
    chk_state(0, 8'h00, "R3 broken by foreign byte");
    wr(D0, 8'h00, 0, 0, 0, "R4 locked data write");
    wr(I0, 8'h87, 0, 0, 0, "R3 key after data write");
    chk_state(0, 8'h00, "R3 broken by data write");
    wr(I0, 8'h87, 0, 0, 0, "R2 second key");
    chk_state(1, 8'h00, "R2 unlocked");
    rd(I0, 8'h00, 0, "R1 index cleared");
    rd(D0, 8'h5A, 1, "R6 read reg 00");
    wr(I0, 8'h20, 0, 0, 0, "R9 select id");
    rd(D0, 8'hA3, 0, "R9 chip id");
    wr(D0, 8'h11, 0, 0, 0, "R9 write to id ignored");
    rd(D0, 8'hA3, 0, "R9 id unchanged");
    wr(I0, 8'h07, 0, 0, 0, "R8 select device reg");
    wr(D0, 8'h03, 0, 0, 0, "R8 device write local");
    chk_state(1, 8'h03, "R8 device number");
    rd(D0, 8'h03, 0, "R8 device readback");
    wr(I0, 8'h30, 0, 0, 0, "R7 select 30");
    wr(D0, 8'h01, 1, 8'h30, 8'h03, "R7 forwarded write");
    rd(D0, 8'h30 ^ 8'h03 ^ 8'h5A, 1, "R6 forwarded read");
    rd(I0, 8'h30, 0, "R11 index readback");
    wr(I0, 8'hF5, 0, 0, 0, "R7 select F5");
    wr(D0, 8'h0C, 1, 8'hF5, 8'h03, "R7 forwarded write F5");
    wr(D1, 8'h44, 0, 0, 0, "R10 other base write");
    rd(I1, 8'hFF, 0, "R10 other base read");
    rd(I0, 8'hF5, 0, "R10 other base write had no effect");
    wr(I0, 8'hAA, 0, 0, 0, "R5 exit key");
    chk_state(0, 8'h03, "R5 locked after exit");
    rd(D0, 8'hFF, 0, "R4 data read after exit");
    wr(D0, 8'h22, 0, 0, 0, "R4 data write after exit");
    idle();
    base_alt = 1;
    wr(I1, 8'h87, 0, 0, 0, "R10 key at alt base");
    wr(I1, 8'h87, 0, 0, 0, "R10 key at alt base");
    chk_state(1, 8'h03, "R10 unlocked at alt base");
    rd(D1, 8'hF5 ^ 8'h03 ^ 8'h5A, 1, "R5 index kept over exit");
    rd(D0, 8'hFF, 0, "R10 old base inactive");
    wr(I1, 8'hAA, 0, 0, 0, "R5 exit at alt base");
    chk_state(0, 8'h03, "R5 locked at alt base");
    idle();
    rst_n = 0;
    repeat (2) idle();
    rst_n = 1;
    chk_state(0, 8'h00, "R1 state after second reset");
    wr(I1, 8'h87, 0, 0, 0, "R2 key");
    wr(I1, 8'h87, 0, 0, 0, "R2 key");
    rd(I1, 8'h00, 0, "R1 index cleared after reset");
    idle();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule